// File: doc/BRIEF.md
# Register-Cached Operand Stack

This block is a last-in first-out operand stack for a stack-oriented processor core. The two newest entries live in registers: T, the top, and N, the one below it. Both are 32 bits wide and drive the two operands of an external ALU directly. Older entries spill into a small internal array. The array has eight entries by default, and each entry is stored as an upper and a lower 16-bit field.

The array is connected only to N. A push moves T into N and writes the old N into the array. A pop refills N from the newest array entry. T is loaded only from the ALU result input, either as a full 32-bit word or through its low 16-bit half. Because the T load and the N/array transfer are separate paths, a pop and a T load complete in the same clock edge. This is how a two-operand ALU instruction consumes N and writes its result to T.

The block keeps a hidden occupancy count. It raises sticky flags when a push finds the array full or a pop finds it empty. In either case the refused transfer leaves the count, N and the array untouched.

Top module: `tn_data_stack`

## Requirements
- R1: After a synchronous active-low reset, `t_o`, `n_o`, `ovf_o` and `unf_o` are all zero and the array holds no entries.
- R2: With `t_load_i`=1 and `t_half_i`=0, `t_o` equals `alu_i` after the next rising edge.
- R3: With `t_load_i`=1 and `t_half_i`=1, `t_o[15:0]` takes `alu_i[15:0]` at the next edge, and `t_o[31:16]` keeps its previous value.
- R4: An accepted push (`push_i`=1, fewer than DEPTH entries stored) sets N to the previous T and stores the previous N as the newest array entry.
- R5: An accepted pop (`pop_i`=1, `push_i`=0, at least one entry stored) loads N with the newest array entry and removes that entry, so entries return in reverse order of storage.
- R6: A push and a T load in the same cycle both take effect: N receives the T value from before the edge, and T receives `alu_i`.
- R7: A pop and a T load in the same cycle both take effect at the same edge.
- R8: A push while DEPTH entries are stored sets `ovf_o`. It leaves N and the stored entries unchanged, and a T load in that cycle still happens.
- R9: A pop (with `push_i`=0) while no entries are stored sets `unf_o` and leaves N unchanged.
- R10: When `push_i` and `pop_i` are both 1, the push is performed and the pop is ignored.
- R11: Once set, `ovf_o` and `unf_o` stay set until reset.
- R12: In a cycle with no strobe asserted, T, N and the stored entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push: T to N, N to array |
| pop_i | input | 1 | Pop: newest array entry to N |
| t_load_i | input | 1 | Load T from the ALU result |
| t_half_i | input | 1 | With t_load_i, write only the low 16 bits of T |
| alu_i | input | 32 | ALU result |
| t_o | output | 32 | Top register, first ALU operand |
| n_o | output | 32 | Next register, second ALU operand |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
A wrong T or N value shows up at `t_o` or `n_o` right after the edge that produced it. A fault in the occupancy count or in the array stays hidden until it is popped back. It can surface up to eight pops later, as the wrong word in `n_o`, or as a flag that rises too early or too late. The bench therefore compares T, N and both flags after every cycle against a model, and it drains the full array after each overflow so that every stored entry comes back through N.

// File: rtl/dstk_pkg.sv
// Package dstk_pkg
// Shared widths and the array entry layout for the cached operand stack.
// Assumes a word is exactly two half-words.
package dstk_pkg;
    parameter int unsigned HALF_W = 16;
    parameter int unsigned WORD_W = 2 * HALF_W;

    // One array entry: upper and lower half-word fields.
    typedef struct packed {
        logic [HALF_W-1:0] upper;
        logic [HALF_W-1:0] lower;
    } entry_t;
endpackage

// File: rtl/dstk_ctrl.sv
// Module dstk_ctrl
// Tracks how many entries are held in the array, decides whether a push or
// a pop is accepted, forms the write and read addresses, and keeps the
// sticky overflow and underflow flags.
// Assumes push has priority over pop when both are requested.
module dstk_ctrl #(
    parameter int unsigned DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic                       pop_i,
    output logic                       push_ok_o,
    output logic                       pop_ok_o,
    output logic [$clog2(DEPTH)-1:0]   wr_addr_o,
    output logic [$clog2(DEPTH)-1:0]   rd_addr_o,
    output logic                       ovf_o,
    output logic                       unf_o
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = PW + 1;

    logic [CW-1:0] count_q;
    logic          full;
    logic          empty;
    logic          pop_req;
    logic          ovf_q;
    logic          unf_q;

    // Occupancy decode and acceptance of the requested transfer.
    always_comb begin
        full      = (count_q == CW'(DEPTH));
        empty     = (count_q == '0);
        pop_req   = pop_i && !push_i;
        push_ok_o = push_i && !full;
        pop_ok_o  = pop_req && !empty;
        wr_addr_o = count_q[PW-1:0];
        rd_addr_o = count_q[PW-1:0] - PW'(1);
    end

    // Occupancy counter: up on an accepted push, down on an accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (push_ok_o)
            count_q <= count_q + CW'(1);
        else if (pop_ok_o)
            count_q <= count_q - CW'(1);
    end

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (push_i && full)
                ovf_q <= 1'b1;
            if (pop_req && empty)
                unf_q <= 1'b1;
        end
    end

    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    // R4: an accepted push raises the occupancy by one.
    a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok_o |=> count_q == $past(count_q) + CW'(1));

    // R8: a push into a full array sets overflow and leaves the count alone.
    a_r8_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full) |=> (ovf_o && $stable(count_q)));

    // R9: a pop from an empty array sets underflow and leaves the count alone.
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty) |=> (unf_o && $stable(count_q)));

    // R11: the flags never fall outside reset.
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    a_r11_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);

    // R10: both transfers are never accepted in one cycle.
    a_r10_one_move: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({push_ok_o, pop_ok_o}) <= 1);
endmodule

// File: rtl/dstk_mem.sv
// Module dstk_mem
// Spill array for the cached operand stack: DEPTH entries, each with two
// half-word fields. One write port and one combinational read port.
// Assumes the controller only writes below DEPTH; contents are not reset.
module dstk_mem #(
    parameter int unsigned DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       we_i,
    input  logic [$clog2(DEPTH)-1:0]   wr_addr_i,
    input  dstk_pkg::entry_t           wr_data_i,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr_i,
    output dstk_pkg::entry_t           rd_data_o
);
    localparam int unsigned PW = $clog2(DEPTH);

    dstk_pkg::entry_t cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        dstk_pkg::entry_t cell_q;

        // Capture the written entry when this slot is addressed.
        always_ff @(posedge clk) begin
            if (we_i && (wr_addr_i == PW'(g)))
                cell_q <= wr_data_i;
        end

        assign cells[g] = cell_q;
    end

    // Combinational read of the newest stored entry.
    always_comb begin
        rd_data_o = cells[rd_addr_i];
    end
endmodule

// File: rtl/dstk_regs.sv
// Module dstk_regs
// The T and N registers. T is loaded only from the ALU result, either as a
// full word or through its low half. N takes T on a push and the array
// read data on a pop.
// Assumes push_ok_i and pop_ok_i are never both high.
module dstk_regs (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           t_load_i,
    input  logic                           t_half_i,
    input  logic [dstk_pkg::WORD_W-1:0]    alu_i,
    input  logic                           push_ok_i,
    input  logic                           pop_ok_i,
    input  logic [dstk_pkg::WORD_W-1:0]    rd_data_i,
    output logic [dstk_pkg::WORD_W-1:0]    t_o,
    output logic [dstk_pkg::WORD_W-1:0]    n_o
);
    localparam int unsigned HW = dstk_pkg::HALF_W;
    localparam int unsigned WW = dstk_pkg::WORD_W;

    logic [WW-1:0] t_q;
    logic [WW-1:0] n_q;

    // Top register: full-word or low-half load from the ALU result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            t_q <= '0;
        else if (t_load_i) begin
            if (t_half_i)
                t_q[HW-1:0] <= alu_i[HW-1:0];
            else
                t_q <= alu_i;
        end
    end

    // Next register: takes T on a push, the array entry on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            n_q <= '0;
        else if (push_ok_i)
            n_q <= t_q;
        else if (pop_ok_i)
            n_q <= rd_data_i;
    end

    assign t_o = t_q;
    assign n_o = n_q;

    // R2: a full-word load places the ALU result in T.
    a_r2_t_full: assert property (@(posedge clk) disable iff (!rst_n)
        (t_load_i && !t_half_i) |=> t_o == $past(alu_i));

    // R3: a half load keeps the upper half of T.
    a_r3_t_half: assert property (@(posedge clk) disable iff (!rst_n)
        (t_load_i && t_half_i) |=> (t_o[WW-1:HW] == $past(t_o[WW-1:HW])
                                    && t_o[HW-1:0] == $past(alu_i[HW-1:0])));

    // R4: an accepted push copies the old T into N.
    a_r4_n_from_t: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok_i |=> n_o == $past(t_o));

    // R5: an accepted pop loads N from the array.
    a_r5_n_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok_i |=> n_o == $past(rd_data_i));

    // R12: without a load or an accepted transfer both registers hold.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!t_load_i && !push_ok_i && !pop_ok_i) |=> ($stable(t_o) && $stable(n_o)));
endmodule

// File: rtl/tn_data_stack.sv
// Module tn_data_stack
// Operand stack whose top two entries are held in registers T and N, with
// older entries in a DEPTH-entry spill array attached only to N. T and N
// feed an external ALU; its result returns on alu_i.
// Assumes DEPTH is a power of two, at least 2.
module tn_data_stack #(
    parameter int unsigned DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  logic        pop_i,
    input  logic        t_load_i,
    input  logic        t_half_i,
    input  logic [31:0] alu_i,
    output logic [31:0] t_o,
    output logic [31:0] n_o,
    output logic        ovf_o,
    output logic        unf_o
);
    localparam int unsigned PW = $clog2(DEPTH);

    logic             push_ok;
    logic             pop_ok;
    logic [PW-1:0]    wr_addr;
    logic [PW-1:0]    rd_addr;
    dstk_pkg::entry_t rd_entry;
    dstk_pkg::entry_t wr_entry;

    dstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .push_ok_o (push_ok),
        .pop_ok_o  (pop_ok),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    // The array is always written from N.
    assign wr_entry = dstk_pkg::entry_t'(n_o);

    dstk_mem #(.DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .we_i      (push_ok),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_entry),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_entry)
    );

    dstk_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .t_load_i  (t_load_i),
        .t_half_i  (t_half_i),
        .alu_i     (alu_i),
        .push_ok_i (push_ok),
        .pop_ok_i  (pop_ok),
        .rd_data_i (rd_entry),
        .t_o       (t_o),
        .n_o       (n_o)
    );

    // R1: the first cycle after reset shows a cleared stack.
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (t_o == '0 && n_o == '0 && !ovf_o && !unf_o));
endmodule

// File: tb/test_tn_data_stack.sv
// Bench for tn_data_stack: directed corners, then seeded random traffic,
// with T, N and both flags compared against a bench model every cycle.
module test_tn_data_stack;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic        t_load_i = 1'b0;
    logic        t_half_i = 1'b0;
    logic [31:0] alu_i = '0;
    logic [31:0] t_o;
    logic [31:0] n_o;
    logic        ovf_o;
    logic        unf_o;

    int tests = 0;
    int fails = 0;

    logic [31:0] m_t;
    logic [31:0] m_n;
    logic [31:0] m_mem [DEPTH];
    int          m_cnt;
    logic        m_ovf;
    logic        m_unf;

    always #2.5 clk = ~clk;

    tn_data_stack #(.DEPTH(DEPTH)) i_tn_data_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .t_load_i(t_load_i), .t_half_i(t_half_i), .alu_i(alu_i),
        .t_o(t_o), .n_o(n_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // Expected T after a load request.
    function automatic logic [31:0] next_t(logic [31:0] t, logic ld, logic half,
                                           logic [31:0] alu);
        if (!ld)  return t;
        if (half) return {t[31:16], alu[15:0]};
        return alu;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "T", t_o, m_t);
        chk(req, "N", n_o, m_n);
        chk(req, "ovf", {31'b0, ovf_o}, {31'b0, m_ovf});
        chk(req, "unf", {31'b0, unf_o}, {31'b0, m_unf});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        push_i = 1'b0; pop_i = 1'b0; t_load_i = 1'b0; t_half_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_t = '0; m_n = '0; m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
    endtask

    // One cycle: drive at a falling edge, update model, compare at next fall.
    task automatic step(string req, logic ps, logic pp, logic ld, logic half,
                        logic [31:0] alu);
        logic [31:0] old_t;
        push_i = ps; pop_i = pp; t_load_i = ld; t_half_i = half; alu_i = alu;
        old_t = m_t;
        if (ps) begin
            if (m_cnt == DEPTH) m_ovf = 1'b1;
            else begin
                m_mem[m_cnt] = m_n;
                m_n = old_t;
                m_cnt++;
            end
        end else if (pp) begin
            if (m_cnt == 0) m_unf = 1'b1;
            else begin
                m_cnt--;
                m_n = m_mem[m_cnt];
            end
        end
        m_t = next_t(old_t, ld, half, alu);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; t_load_i = 1'b0; t_half_i = 1'b0;
        check_all(req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        check_all("R1");
        // R1/R9: empty after reset, so a pop underflows and N stays zero
        step("R9", 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
        step("R11", 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        do_reset();
        check_all("R1");

        // R2 and R3: T loads
        step("R2", 1'b0, 1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF);
        step("R3", 1'b0, 1'b0, 1'b1, 1'b1, 32'h1234_5678);
        step("R12", 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF);

        // R4/R6: pushes with new T each cycle
        for (int k = 0; k < 3; k++)
            step("R6", 1'b1, 1'b0, 1'b1, 1'b0, 32'hA000_0000 + 32'(k));
        step("R4", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);

        // R5/R7: pops with simultaneous T load
        step("R7", 1'b0, 1'b1, 1'b1, 1'b0, 32'h0BAD_F00D);
        step("R5", 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);

        // R10: push and pop together, push wins
        step("R10", 1'b1, 1'b1, 1'b1, 1'b0, 32'h7777_1111);

        // R8: fill, overflow with a T load, then drain through N
        while (m_cnt < DEPTH)
            step("R4", 1'b1, 1'b0, 1'b1, 1'b0, 32'hC000_0000 + 32'(m_cnt));
        step("R8", 1'b1, 1'b0, 1'b1, 1'b0, 32'h8888_9999);
        step("R8", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        while (m_cnt > 0)
            step("R5", 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
        step("R9", 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
        step("R11", 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);

        // Random traffic from a clean state
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic ps, pp;
            r  = $urandom % 100;
            ps = (r < 42);
            pp = (r >= 38 && r < 82);
            step((ps || pp) ? "R5" : "R12", ps, pp, 1'(($urandom % 3) != 0),
                 1'(($urandom % 4) == 0), 32'($urandom));
            if (m_cnt == DEPTH) begin
                step("R8", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
                while (m_cnt > 0)
                    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, 32'($urandom));
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule